// File: doc/BRIEF.md
# Audio PCM Slot DMA Request Packer

This block connects the PCM part of an AC'97-style frame engine to a system DMA controller. It handles only the two audio sample slots: slot 3 carries the left channel and slot 4 carries the right channel. It serves both the capture path and the playback path.

On the capture side, the frame engine delivers the two 20-bit slot samples of each frame. The block converts them into 32-bit bus words, raises a DMA request and drives the word on a read port until the controller reads it. On the playback side, the block requests 32-bit words, accepts them through a write strobe and hands slot samples to the frame engine each time the engine asks for a frame.

Each direction has three control bits: DMA enable, 16-bit sample size and mono. These bits decide how samples map onto bus words and how many requests a frame needs.

Top module: `audio_slot_dma`

Capture state machine (`rx_state_t`):
- `RX_EMPTY`: nothing is pending.
- `RX_LEFT`: the slot 3 word is pending.
- `RX_GAP`: the single idle cycle between the two words of a stereo 20-bit frame.
- `RX_RIGHT`: the slot 4 word is pending.
- `RX_PACKED`: the packed 16-bit word is pending.

Capture transitions:
- A frame arrives in EMPTY: the block goes to PACKED (16-bit) or to LEFT (20-bit).
- The LEFT word is read: the block goes to GAP (stereo) or to EMPTY (mono).
- GAP always moves to RIGHT on the next cycle.
- The RIGHT word or the PACKED word is read: the block goes to EMPTY.

Playback state machine (`tx_state_t`):
- `TX_EMPTY`: the first word of a frame is requested.
- `TX_GAP`: the idle cycle after the slot 3 word of a stereo 20-bit frame.
- `TX_NEED_R`: the slot 4 word is requested.
- `TX_FULL`: the frame is complete.

Playback transitions:
- A write in EMPTY goes to FULL (16-bit, or mono 20-bit) or to GAP (stereo 20-bit).
- GAP always moves to NEED_R on the next cycle.
- A write in NEED_R goes to FULL.
- A frame request from the engine, in any state, returns the machine to EMPTY.

## Requirements
- R1: Capture, 16-bit stereo (`rx_size16`=1, `rx_mono`=0). Each frame gives one word: bits 31:16 hold the upper 16 bits of slot 3 and bits 15:0 hold the upper 16 bits of slot 4. One request and one read serve the frame.
- R2: Capture, 20-bit stereo (`rx_size16`=0, `rx_mono`=0). The block gives two words in order: slot 3 first, then slot 4. Each word carries its sample in bits 19:0 and zeros in bits 31:20. Each word has its own request, and the request stays low for exactly one cycle between the two words.
- R3: Capture, mono (`rx_mono`=1). Only slot 3 is served and slot 4 has no effect. In 16-bit mode the word is the slot 3 sample in bits 31:16 with bits 15:0 zero. In 20-bit mode the frame has one word only.
- R4: A request is a level. It stays high until the matching access (`rx_rd` or `tx_wr`) is taken, and it is low in the cycle after that access. The exception is a frame event in that same cycle, which starts a new frame.
- R5: Clearing a direction's DMA enable drops its request in the same cycle. While the enable is low, accesses of that direction are ignored and the pending data is kept. Setting the enable again brings the request back with the same data.
- R6: A capture frame that arrives while data is still unread is discarded. `rx_overrun` is high for one cycle, in the cycle after that frame.
- R7: Playback, 16-bit stereo. One write fills the frame. Slot 3 becomes write bits 31:16 followed by 4 zero bits, and slot 4 becomes write bits 15:0 followed by 4 zero bits.
- R8: Playback, 20-bit stereo. Two writes fill the frame: the first gives slot 3 from bits 19:0 and the second gives slot 4 from bits 19:0. The request stays low for exactly one cycle between the two writes.
- R9: Playback, mono. One write fills the frame and slot 4 is sent as zero. In 16-bit mode slot 3 is {bits 31:16, 4'b0}; in 20-bit mode it is bits 19:0.
- R10: A `tx_frame_req` pulse sets `tx_slot3` and `tx_slot4` in the next cycle. If the frame is incomplete, both slots are zero and `tx_underrun` is high for that one cycle. The partial data is dropped and a new frame starts.
- R11: When a bus access and a frame event fall in the same cycle, the access completes first. The frame event then sees the state the access left behind.
- R12: After reset, both requests and both flags are low, `rx_rdata` is zero and both output slots are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dma_en | input | 1 | Capture DMA enable |
| rx_size16 | input | 1 | Capture sample size: 1 = 16-bit, 0 = 20-bit |
| rx_mono | input | 1 | Capture mono (slot 3 only) |
| tx_dma_en | input | 1 | Playback DMA enable |
| tx_size16 | input | 1 | Playback sample size: 1 = 16-bit, 0 = 20-bit |
| tx_mono | input | 1 | Playback mono (slot 4 sent as zero) |
| rx_frame_vld | input | 1 | Pulse: the frame engine has captured a new frame |
| rx_slot3 | input | 20 | Captured slot 3 sample |
| rx_slot4 | input | 20 | Captured slot 4 sample |
| rx_dreq | output | 1 | Capture DMA request |
| rx_rd | input | 1 | Bus read strobe for the capture word |
| rx_rdata | output | 32 | Capture word, zero while no request is raised |
| rx_overrun | output | 1 | One-cycle capture overrun flag |
| tx_dreq | output | 1 | Playback DMA request |
| tx_wr | input | 1 | Bus write strobe for a playback word |
| tx_wdata | input | 32 | Playback write data |
| tx_frame_req | input | 1 | Pulse: the frame engine needs the next playback samples |
| tx_slot3 | output | 20 | Playback slot 3 sample |
| tx_slot4 | output | 20 | Playback slot 4 sample |
| tx_underrun | output | 1 | One-cycle playback underrun flag |

## Verification
Two functions can fall in the same cycle in each direction.

On capture, a read of the pending word can coincide with a new frame. On playback, a write can coincide with the frame engine's request.

The bench provokes both cases by driving the bus strobe and the frame pulse together in several states:
- the packed word;
- the last slot 4 word;
- the first slot 3 word of a stereo 20-bit frame.

A behavioural queue model applies the access before the frame event, and so predicts one of two outcomes: a clean hand-over, or an overrun or underrun. The model is compared against the design on every cycle.

// File: rtl/audio_slot_dma_pkg.sv
package audio_slot_dma_pkg;

    typedef enum logic [2:0] {
        RX_EMPTY  = 3'd0,
        RX_LEFT   = 3'd1,
        RX_GAP    = 3'd2,
        RX_RIGHT  = 3'd3,
        RX_PACKED = 3'd4
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_EMPTY  = 2'd0,
        TX_GAP    = 2'd1,
        TX_NEED_R = 2'd2,
        TX_FULL   = 2'd3
    } tx_state_t;

endpackage

// File: rtl/rx_slot_packer.sv
module rx_slot_packer
    import audio_slot_dma_pkg::*;
#(
    parameter int SLOT_W = 20,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              size16,
    input  logic              mono,
    input  logic              frame_vld,
    input  logic [SLOT_W-1:0] slot3,
    input  logic [SLOT_W-1:0] slot4,
    input  logic              rd,
    output logic              dreq,
    output logic [BUS_W-1:0]  rdata,
    output logic              overrun
);
    localparam int PCM_W = BUS_W / 2;
    localparam int PAD_W = BUS_W - SLOT_W;

    rx_state_t        state_q, state_r, state_n;
    logic [BUS_W-1:0] word_l_q, word_l_n, word_r_q, word_r_n;
    logic             mono_q, mono_n;
    logic             ovr_q, ovr_n;
    logic             take;

    // Next-state logic: the bus read is applied first, the frame event second.
    always_comb begin
        take    = dreq && rd;
        state_r = state_q;
        if (take) begin
            unique case (state_q)
                RX_LEFT:             state_r = mono_q ? RX_EMPTY : RX_GAP;
                RX_RIGHT, RX_PACKED: state_r = RX_EMPTY;
                default:             state_r = state_q;
            endcase
        end else if (state_q == RX_GAP) begin
            state_r = RX_RIGHT;
        end

        state_n  = state_r;
        word_l_n = word_l_q;
        word_r_n = word_r_q;
        mono_n   = mono_q;
        ovr_n    = 1'b0;

        if (frame_vld) begin
            if (state_r == RX_EMPTY) begin
                mono_n = mono;
                if (size16) begin
                    word_l_n = {slot3[SLOT_W-1 -: PCM_W],
                                mono ? {PCM_W{1'b0}} : slot4[SLOT_W-1 -: PCM_W]};
                    word_r_n = '0;
                    state_n  = RX_PACKED;
                end else begin
                    word_l_n = {{PAD_W{1'b0}}, slot3};
                    word_r_n = mono ? '0 : {{PAD_W{1'b0}}, slot4};
                    state_n  = RX_LEFT;
                end
            end else begin
                ovr_n = 1'b1;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RX_EMPTY;
            word_l_q <= '0;
            word_r_q <= '0;
            mono_q   <= 1'b0;
            ovr_q    <= 1'b0;
        end else begin
            state_q  <= state_n;
            word_l_q <= word_l_n;
            word_r_q <= word_r_n;
            mono_q   <= mono_n;
            ovr_q    <= ovr_n;
        end
    end

    // Outputs
    always_comb begin
        dreq    = 1'b0;
        rdata   = '0;
        overrun = ovr_q;
        unique case (state_q)
            RX_LEFT, RX_PACKED: begin
                dreq  = dma_en;
                rdata = dma_en ? word_l_q : '0;
            end
            RX_RIGHT: begin
                dreq  = dma_en;
                rdata = dma_en ? word_r_q : '0;
            end
            default: begin
                dreq  = 1'b0;
                rdata = '0;
            end
        endcase
    end

    AST_RX_REQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq && rd && !frame_vld) |=> !dreq); // R4

    AST_RX_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq && !rd && dma_en) |=> (dreq || !dma_en)); // R4

    AST_RX_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_en && !frame_vld && state_q != RX_GAP) |=> $stable(state_q)); // R5

    AST_RX_OVR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> ($stable(word_l_q) && $stable(word_r_q))); // R6

    AST_RX_WIDE_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq && state_q != RX_PACKED) |-> (rdata[BUS_W-1:SLOT_W] == '0)); // R2

endmodule

// File: rtl/tx_slot_packer.sv
module tx_slot_packer
    import audio_slot_dma_pkg::*;
#(
    parameter int SLOT_W = 20,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              size16,
    input  logic              mono,
    input  logic              wr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              frame_req,
    output logic              dreq,
    output logic [SLOT_W-1:0] slot3,
    output logic [SLOT_W-1:0] slot4,
    output logic              underrun
);
    localparam int PCM_W = BUS_W / 2;
    localparam int LOW_W = SLOT_W - PCM_W;

    tx_state_t         state_q, state_w, state_n;
    logic [SLOT_W-1:0] b3_q, b3_w, b4_q, b4_w;
    logic [SLOT_W-1:0] s3_q, s3_n, s4_q, s4_n;
    logic              und_q, und_n;
    logic              take;

    // Next-state logic: the bus write is applied first, the frame request second.
    always_comb begin
        take    = dreq && wr;
        state_w = state_q;
        b3_w    = b3_q;
        b4_w    = b4_q;
        unique case (state_q)
            TX_EMPTY: begin
                if (take) begin
                    if (size16) begin
                        b3_w    = {wdata[BUS_W-1 -: PCM_W], {LOW_W{1'b0}}};
                        b4_w    = mono ? '0 : {wdata[PCM_W-1:0], {LOW_W{1'b0}}};
                        state_w = TX_FULL;
                    end else begin
                        b3_w    = wdata[SLOT_W-1:0];
                        b4_w    = '0;
                        state_w = mono ? TX_FULL : TX_GAP;
                    end
                end
            end
            TX_GAP: state_w = TX_NEED_R;
            TX_NEED_R: begin
                if (take) begin
                    b4_w    = wdata[SLOT_W-1:0];
                    state_w = TX_FULL;
                end
            end
            default: state_w = state_q;
        endcase

        state_n = state_w;
        s3_n    = s3_q;
        s4_n    = s4_q;
        und_n   = 1'b0;
        if (frame_req) begin
            state_n = TX_EMPTY;
            if (state_w == TX_FULL) begin
                s3_n = b3_w;
                s4_n = b4_w;
            end else begin
                s3_n  = '0;
                s4_n  = '0;
                und_n = 1'b1;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_EMPTY;
            b3_q    <= '0;
            b4_q    <= '0;
            s3_q    <= '0;
            s4_q    <= '0;
            und_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            b3_q    <= b3_w;
            b4_q    <= b4_w;
            s3_q    <= s3_n;
            s4_q    <= s4_n;
            und_q   <= und_n;
        end
    end

    // Outputs
    always_comb begin
        slot3    = s3_q;
        slot4    = s4_q;
        underrun = und_q;
        unique case (state_q)
            TX_EMPTY, TX_NEED_R: dreq = dma_en;
            default:             dreq = 1'b0;
        endcase
    end

    AST_TX_REQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq && wr && !frame_req) |=> !dreq); // R4

    AST_TX_UNDER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (slot3 == '0 && slot4 == '0)); // R10

    AST_TX_SLOTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_req |=> ($stable(slot3) && $stable(slot4))); // R10

    AST_TX_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_en && !frame_req && state_q != TX_GAP) |=> $stable(state_q)); // R5

endmodule

// File: rtl/audio_slot_dma.sv
module audio_slot_dma #(
    parameter int SLOT_W = 20,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_dma_en,
    input  logic              rx_size16,
    input  logic              rx_mono,
    input  logic              tx_dma_en,
    input  logic              tx_size16,
    input  logic              tx_mono,
    input  logic              rx_frame_vld,
    input  logic [SLOT_W-1:0] rx_slot3,
    input  logic [SLOT_W-1:0] rx_slot4,
    output logic              rx_dreq,
    input  logic              rx_rd,
    output logic [BUS_W-1:0]  rx_rdata,
    output logic              rx_overrun,
    output logic              tx_dreq,
    input  logic              tx_wr,
    input  logic [BUS_W-1:0]  tx_wdata,
    input  logic              tx_frame_req,
    output logic [SLOT_W-1:0] tx_slot3,
    output logic [SLOT_W-1:0] tx_slot4,
    output logic              tx_underrun
);

    rx_slot_packer #(.SLOT_W(SLOT_W), .BUS_W(BUS_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .dma_en    (rx_dma_en),
        .size16    (rx_size16),
        .mono      (rx_mono),
        .frame_vld (rx_frame_vld),
        .slot3     (rx_slot3),
        .slot4     (rx_slot4),
        .rd        (rx_rd),
        .dreq      (rx_dreq),
        .rdata     (rx_rdata),
        .overrun   (rx_overrun)
    );

    tx_slot_packer #(.SLOT_W(SLOT_W), .BUS_W(BUS_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .dma_en    (tx_dma_en),
        .size16    (tx_size16),
        .mono      (tx_mono),
        .wr        (tx_wr),
        .wdata     (tx_wdata),
        .frame_req (tx_frame_req),
        .dreq      (tx_dreq),
        .slot3     (tx_slot3),
        .slot4     (tx_slot4),
        .underrun  (tx_underrun)
    );

    AST_RX_OVR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !rx_frame_vld) |=> !rx_overrun); // R6

    AST_TX_UND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_underrun && !tx_frame_req) |=> !tx_underrun); // R10

endmodule

// File: tb/sim_audio_slot_dma.sv
module sim_audio_slot_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 0, rx_s16 = 0, rx_mono = 0;
    logic        tx_en = 0, tx_s16 = 0, tx_mono = 0;
    logic        rx_frame_vld = 0, rx_rd = 0, tx_wr = 0, tx_frame_req = 0;
    logic [19:0] rx_slot3 = '0, rx_slot4 = '0;
    logic [31:0] tx_wdata = '0;
    logic        rx_dreq, rx_overrun, tx_dreq, tx_underrun;
    logic [31:0] rx_rdata;
    logic [19:0] tx_slot3, tx_slot4;

    always #4 clk = ~clk;

    audio_slot_dma u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_dma_en(rx_en), .rx_size16(rx_s16), .rx_mono(rx_mono),
        .tx_dma_en(tx_en), .tx_size16(tx_s16), .tx_mono(tx_mono),
        .rx_frame_vld(rx_frame_vld), .rx_slot3(rx_slot3), .rx_slot4(rx_slot4),
        .rx_dreq(rx_dreq), .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_overrun(rx_overrun),
        .tx_dreq(tx_dreq), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_frame_req(tx_frame_req),
        .tx_slot3(tx_slot3), .tx_slot4(tx_slot4), .tx_underrun(tx_underrun)
    );

    int    n_run = 0, n_fail = 0, cycles = 0;
    bit    done = 0;
    string cur_req = "R12";
    bit    auto_rx = 0, auto_tx = 0;
    logic [31:0] pat = 32'h1234_5A5B;

    // Behavioural reference model
    logic [31:0] rxq[$];
    int   rgap = 0, tw = 0, tneed = 0, tgap = 0;
    logic ovr_e = 0, und_e = 0;
    logic [19:0] es3 = '0, es4 = '0, ts3 = '0, ts4 = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            rxq.delete();
            rgap = 0; ovr_e = 0;
            tw = 0; tneed = 0; tgap = 0; und_e = 0;
            es3 = '0; es4 = '0;
        end else begin
            // capture: read first, then frame
            if (rgap != 0) rgap = 0;
            else if (rx_rd && rx_en && rxq.size() > 0) begin
                void'(rxq.pop_front());
                if (rxq.size() > 0) rgap = 1;
            end
            ovr_e = 0;
            if (rx_frame_vld) begin
                if (rxq.size() == 0) begin
                    if (rx_s16)
                        rxq.push_back({rx_slot3[19:4], rx_mono ? 16'h0 : rx_slot4[19:4]});
                    else begin
                        rxq.push_back({12'h0, rx_slot3});
                        if (!rx_mono) rxq.push_back({12'h0, rx_slot4});
                    end
                end else ovr_e = 1;
            end
            // playback: write first, then frame request
            if (tgap != 0) tgap = 0;
            else if (tx_wr && tx_en && (tw == 0 || tw < tneed)) begin
                if (tw == 0) begin
                    if (tx_s16) begin
                        tneed = 1;
                        ts3 = {tx_wdata[31:16], 4'h0};
                        ts4 = tx_mono ? 20'h0 : {tx_wdata[15:0], 4'h0};
                    end else begin
                        tneed = tx_mono ? 1 : 2;
                        ts3 = tx_wdata[19:0];
                        ts4 = 20'h0;
                    end
                end else ts4 = tx_wdata[19:0];
                tw = tw + 1;
                if (tw < tneed) tgap = 1;
            end
            und_e = 0;
            if (tx_frame_req) begin
                if (tw > 0 && tw == tneed) begin es3 = ts3; es4 = ts4; end
                else begin es3 = '0; es4 = '0; und_e = 1; end
                tw = 0; tneed = 0; tgap = 0;
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic        e_rreq, e_treq;
        logic [31:0] e_rdata;
        e_rreq  = rx_en && rxq.size() > 0 && rgap == 0;
        e_rdata = e_rreq ? rxq[0] : 32'h0;
        e_treq  = tx_en && tgap == 0 && (tw == 0 || tw < tneed);
        chk("rx_dreq", {31'h0, rx_dreq}, {31'h0, e_rreq});
        chk("rx_rdata", rx_rdata, e_rdata);
        chk("rx_overrun", {31'h0, rx_overrun}, {31'h0, ovr_e});
        chk("tx_dreq", {31'h0, tx_dreq}, {31'h0, e_treq});
        chk("tx_slot3", {12'h0, tx_slot3}, {12'h0, es3});
        chk("tx_slot4", {12'h0, tx_slot4}, {12'h0, es4});
        chk("tx_underrun", {31'h0, tx_underrun}, {31'h0, und_e});
    endtask

    // One clock: update at the edge, compare at the falling edge, then clear pulses
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        rx_frame_vld = 0; rx_rd = 0; tx_wr = 0; tx_frame_req = 0;
        if (auto_rx && rx_dreq) rx_rd = 1;
        if (auto_tx && tx_dreq) begin
            tx_wr = 1;
            tx_wdata = pat;
            pat = {pat[30:0], pat[31] ^ pat[21] ^ pat[1] ^ pat[0]} + 32'h0001_0203;
        end
    endtask

    task automatic rx_frame(input logic [19:0] a, input logic [19:0] b);
        rx_slot3 = a; rx_slot4 = b; rx_frame_vld = 1;
        step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 50000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;

        // R12: reset state
        cur_req = "R12";
        @(negedge clk);
        chk("reset rx_dreq", {31'h0, rx_dreq}, 32'h0);
        chk("reset rx_rdata", rx_rdata, 32'h0);
        chk("reset tx_slot3", {12'h0, tx_slot3}, 32'h0);
        chk("reset flags", {30'h0, rx_overrun, tx_underrun}, 32'h0);
        idle(2);

        // R1: 16-bit stereo capture
        cur_req = "R1";
        rx_en = 1; rx_s16 = 1; rx_mono = 0; auto_rx = 1;
        for (int k = 0; k < 4; k++) begin
            rx_frame(20'hA1B2C + 20'(k * 4097), 20'h3D4E5 ^ 20'(k * 333));
            idle(4);
        end

        // R2: 20-bit stereo capture with gap between the words
        cur_req = "R2";
        rx_s16 = 0;
        for (int k = 0; k < 4; k++) begin
            rx_frame(20'hFFFFF - 20'(k * 77), 20'h00F0F + 20'(k * 1000));
            idle(6);
        end

        // R3: mono capture, both sizes; slot 4 must not appear
        cur_req = "R3";
        rx_mono = 1;
        rx_frame(20'h12345, 20'hFFFFF); idle(5);
        rx_s16 = 1;
        rx_frame(20'h6789A, 20'hFFFFF); idle(5);
        rx_mono = 0;

        // R5: enable cleared with a word pending, reads ignored, then resumed
        cur_req = "R5";
        auto_rx = 0; rx_s16 = 0;
        rx_frame(20'hCAFE1, 20'hBEEF2);
        rx_en = 0; step();
        rx_rd = 1; step();
        rx_rd = 1; step();
        rx_en = 1; step();
        chk("resume word", rx_rdata, 32'h000CAFE1);
        auto_rx = 1; idle(6);

        // R6: frames back to back without service
        cur_req = "R6";
        auto_rx = 0; rx_s16 = 1;
        rx_frame(20'h11111, 20'h22222);
        rx_frame(20'h33333, 20'h44444);
        chk("overrun pulse", {31'h0, rx_overrun}, 32'h1);
        step();
        chk("kept first", rx_rdata, 32'h11112222);
        auto_rx = 1; idle(4);

        // R11: read and frame in the same cycle
        cur_req = "R11";
        auto_rx = 0;
        rx_frame(20'h55555, 20'h66666); step();
        rx_rd = 1; rx_slot3 = 20'h77777; rx_slot4 = 20'h88888; rx_frame_vld = 1; step();
        rx_s16 = 0;
        rx_rd = 1; step(); step();          // packed word read, now empty
        rx_frame(20'h9ABCD, 20'hEF012); step();
        rx_rd = 1; rx_frame_vld = 1; step(); // left read + frame: overrun
        step(); rx_rd = 1; step();           // right read
        rx_frame(20'h13579, 20'h2468A); rx_rd = 1; step(); step();
        rx_rd = 1; rx_slot3 = 20'h0F0F0; rx_slot4 = 20'h0A0A0; rx_frame_vld = 1; step();
        auto_rx = 1; idle(8);

        // R7: 16-bit stereo playback
        cur_req = "R7";
        tx_en = 1; tx_s16 = 1; tx_mono = 0; auto_tx = 1;
        for (int k = 0; k < 3; k++) begin idle(5); tx_frame_req = 1; step(); end

        // R8: 20-bit stereo playback
        cur_req = "R8";
        tx_s16 = 0;
        for (int k = 0; k < 3; k++) begin idle(6); tx_frame_req = 1; step(); end

        // R9: mono playback in both sizes
        cur_req = "R9";
        tx_mono = 1;
        idle(5); tx_frame_req = 1; step();
        tx_s16 = 1;
        idle(5); tx_frame_req = 1; step();
        tx_mono = 0;

        // R10: frame request without data, and with only half a frame
        cur_req = "R10";
        idle(4);
        auto_tx = 0; tx_s16 = 0;
        tx_frame_req = 1; step();              // consumes the full frame
        tx_en = 0; tx_frame_req = 1; step();   // nothing written
        chk("underrun", {31'h0, tx_underrun}, 32'h1);
        tx_en = 1; tx_wr = 1; tx_wdata = 32'h000ABCDE; step();
        tx_frame_req = 1; step();              // half frame only
        step();

        // R11: write and frame request in the same cycle
        cur_req = "R11";
        tx_s16 = 1;
        tx_wr = 1; tx_wdata = 32'hDEAD_BEEF; tx_frame_req = 1; step();
        tx_s16 = 0;
        tx_wr = 1; tx_wdata = 32'h00011111; step(); step();
        tx_wr = 1; tx_wdata = 32'h00022222; tx_frame_req = 1; step();
        tx_wr = 1; tx_wdata = 32'h00033333; tx_frame_req = 1; step();
        step();

        // R4: request held through stalls, then dropped after the access
        cur_req = "R4";
        tx_s16 = 1;
        idle(5);
        tx_wr = 1; tx_wdata = 32'h0102_0304; step();
        chk("tx req low after write", {31'h0, tx_dreq}, 32'h0);
        tx_frame_req = 1; step();
        auto_rx = 0; rx_s16 = 1;
        rx_frame(20'hAAAAA, 20'h55555); idle(4);
        chk("rx req held", {31'h0, rx_dreq}, 32'h1);
        rx_rd = 1; step();
        chk("rx req low after read", {31'h0, rx_dreq}, 32'h0);
        idle(3);

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule